// File: doc/BRIEF.md
# Atomic Read-Modify-Write Unit

This block carries out indivisible read-modify-write operations on a word-addressed synchronous memory, as used to build locks. A request gives an operation (swap or fetch-and-add), a signed displacement, two index values with a flag for each saying whether the slot names a real register, and the value of the source register. The unit forms the word address, reads the current word, writes back either the source value (swap) or the sum of the old word and the source value (fetch-and-add), and hands back the old word. The caller writes that old word into the same source register that supplied the operand.

An index slot that is flagged as unused stands for a hidden register that always reads zero, so its value input has no effect. A request whose source is not a register, or whose destination is not a memory reference, is illegal. It is answered with an error and makes no memory access at all. While an operation is in flight the unit holds `busy` high, and further start strobes are dropped. An arbiter outside the block uses `busy` to keep other masters off the memory between the read and the write.

Top module: `atomic_rmw_unit`

## Requirements
- R1: After reset `busy`, `done`, `errFlag`, `memRdEn` and `memWrEn` are all low.
- R2: The word address equals the sign-extended displacement plus both index contributions, taken modulo 2^ADDR_W. With the defaults this is modulo 256.
- R3: An index slot whose use flag is 0 contributes zero, whatever its value input carries.
- R4: A swap (`opSel`=0) writes the source value to the addressed word and returns the previous word on `oldVal`.
- R5: A fetch-and-add (`opSel`=1) writes the previous word plus the source value, modulo 2^32, and returns the previous word on `oldVal`.
- R6: Take a request accepted at clock edge t. `memRdEn` is high in the cycle after edge t. Read data is expected one cycle after the read strobe. `memWrEn` is high in the cycle after edge t+2. `done` is high for one cycle after edge t+3. `busy` is high from edge t until edge t+4.
- R7: A legal operation makes exactly one read and one write, to the same address. No other access occurs between them.
- R8: If `srcIsReg`=0 or `dstIsMem`=0, the unit makes no memory access. `done` and `errFlag` are then high together for the one cycle after acceptance.
- R9: A start strobe that arrives while `busy` is high is ignored.
- R10: A negative displacement, given as two's complement on `disp`, lowers the address by its magnitude.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request strobe, accepted only when not busy |
| opSel | input | 1 | 0 = swap, 1 = fetch-and-add |
| srcIsReg | input | 1 | Source operand is a register (required) |
| dstIsMem | input | 1 | Destination operand is a memory reference (required) |
| disp | input | DISP_W | Signed displacement |
| idx1Used | input | 1 | First index slot names a real register |
| idx1Val | input | DATA_W | First index register value |
| idx2Used | input | 1 | Second index slot names a real register |
| idx2Val | input | DATA_W | Second index register value |
| srcVal | input | DATA_W | Source register value |
| memRdEn | output | 1 | Memory read strobe |
| memWrEn | output | 1 | Memory write strobe |
| memAddr | output | ADDR_W | Memory word address |
| memWrData | output | DATA_W | Memory write data |
| memRdData | input | DATA_W | Memory read data, valid one cycle after the read strobe |
| busy | output | 1 | Operation in flight |
| done | output | 1 | One-cycle completion pulse |
| errFlag | output | 1 | Illegal request, valid with `done` |
| oldVal | output | DATA_W | Previous memory word, for the source register |

## Verification
The assertions assume that the memory answers a read strobe with data on the next cycle. They also assume that no master other than this unit touches the memory while `busy` is high. Under those assumptions, address equality between the read and the write, and the write following the read by exactly two cycles, describe atomicity. The bench memory is a one-cycle registered array driven only by the unit, and the bench has a single requester. This keeps the stimulus inside those assumptions. The stimulus still covers starts issued mid-operation and illegal operand combinations.

// File: rtl/atomic_rmw_pkg.sv
package atomic_rmw_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_READ = 3'd1,
    ST_CAPT = 3'd2,
    ST_WRIT = 3'd3,
    ST_FINI = 3'd4,
    ST_FERR = 3'd5
  } rmwState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic latchOps;
    logic rdEn;
    logic capOld;
    logic wrEn;
    logic finOk;
    logic finErr;
  } rmwStrobe_t;

  localparam logic OP_SWAP = 1'b0;
  localparam logic OP_FADD = 1'b1;

endpackage

// File: rtl/atomic_rmw_ctrl.sv
module atomic_rmw_ctrl
  import atomic_rmw_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       srcIsReg,
  input  logic       dstIsMem,
  output rmwStrobe_t strobe,
  output logic       busy
);

  rmwState_t state, nextState;
  logic legalReq;
  logic accept;

  assign legalReq = srcIsReg && dstIsMem;
  assign accept   = (state == ST_IDLE) && start;

  always_comb begin
    nextState = state;
    unique case (state)
      ST_IDLE: if (start) nextState = legalReq ? ST_READ : ST_FERR;
      ST_READ: nextState = ST_CAPT;
      ST_CAPT: nextState = ST_WRIT;
      ST_WRIT: nextState = ST_FINI;
      ST_FINI: nextState = ST_IDLE;
      ST_FERR: nextState = ST_IDLE;
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    strobe.latchOps = accept && legalReq;
    strobe.rdEn     = (state == ST_READ);
    strobe.capOld   = (state == ST_CAPT);
    strobe.wrEn     = (state == ST_WRIT);
    strobe.finOk    = (state == ST_FINI);
    strobe.finErr   = (state == ST_FERR);
  end

  assign busy = (state != ST_IDLE);

endmodule

// File: rtl/atomic_rmw_dp.sv
module atomic_rmw_dp
  import atomic_rmw_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8,
  parameter int DISP_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  rmwStrobe_t        strobe,
  input  logic              opSel,
  input  logic [DISP_W-1:0] disp,
  input  logic              idx1Used,
  input  logic [DATA_W-1:0] idx1Val,
  input  logic              idx2Used,
  input  logic [DATA_W-1:0] idx2Val,
  input  logic [DATA_W-1:0] srcVal,
  input  logic [DATA_W-1:0] memRdData,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWrData,
  output logic [DATA_W-1:0] oldVal
);

  localparam int NUM_IDX = 2;
  localparam int EXT_W   = DATA_W - DISP_W;

  logic [DATA_W-1:0] idxRaw  [NUM_IDX];
  logic              idxUse  [NUM_IDX];
  logic [DATA_W-1:0] idxEff  [NUM_IDX];
  logic [DATA_W-1:0] dispExt;
  logic [DATA_W-1:0] effSum;

  logic [ADDR_W-1:0] addrReg;
  logic [DATA_W-1:0] srcReg;
  logic [DATA_W-1:0] oldReg;
  logic              opReg;

  assign idxRaw[0] = idx1Val;
  assign idxRaw[1] = idx2Val;
  assign idxUse[0] = idx1Used;
  assign idxUse[1] = idx2Used;

  // an unused slot maps to the hidden zero register
  for (genvar g = 0; g < NUM_IDX; g++) begin : g_idx
    assign idxEff[g] = idxUse[g] ? idxRaw[g] : '0;
  end

  assign dispExt = {{EXT_W{disp[DISP_W-1]}}, disp};
  assign effSum  = dispExt + idxEff[0] + idxEff[1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrReg <= '0;
      srcReg  <= '0;
      opReg   <= OP_SWAP;
      oldReg  <= '0;
    end else begin
      if (strobe.latchOps) begin
        addrReg <= effSum[ADDR_W-1:0];
        srcReg  <= srcVal;
        opReg   <= opSel;
      end
      if (strobe.capOld) oldReg <= memRdData;
    end
  end

  assign memAddr   = addrReg;
  assign memWrData = (opReg == OP_FADD) ? (oldReg + srcReg) : srcReg;
  assign oldVal    = oldReg;

endmodule

// File: rtl/atomic_rmw_unit.sv
module atomic_rmw_unit
  import atomic_rmw_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8,
  parameter int DISP_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              opSel,
  input  logic              srcIsReg,
  input  logic              dstIsMem,
  input  logic [DISP_W-1:0] disp,
  input  logic              idx1Used,
  input  logic [DATA_W-1:0] idx1Val,
  input  logic              idx2Used,
  input  logic [DATA_W-1:0] idx2Val,
  input  logic [DATA_W-1:0] srcVal,
  output logic              memRdEn,
  output logic              memWrEn,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWrData,
  input  logic [DATA_W-1:0] memRdData,
  output logic              busy,
  output logic              done,
  output logic              errFlag,
  output logic [DATA_W-1:0] oldVal
);

  rmwStrobe_t strobe;

  atomic_rmw_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .srcIsReg (srcIsReg),
    .dstIsMem (dstIsMem),
    .strobe   (strobe),
    .busy     (busy)
  );

  atomic_rmw_dp #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W),
    .DISP_W (DISP_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .opSel     (opSel),
    .disp      (disp),
    .idx1Used  (idx1Used),
    .idx1Val   (idx1Val),
    .idx2Used  (idx2Used),
    .idx2Val   (idx2Val),
    .srcVal    (srcVal),
    .memRdData (memRdData),
    .memAddr   (memAddr),
    .memWrData (memWrData),
    .oldVal    (oldVal)
  );

  assign memRdEn = strobe.rdEn;
  assign memWrEn = strobe.wrEn;
  assign done    = strobe.finOk | strobe.finErr;
  assign errFlag = strobe.finErr;

endmodule

// File: rtl/atomic_rmw_chk.sv
module atomic_rmw_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              memRdEn,
  input logic              memWrEn,
  input logic [ADDR_W-1:0] memAddr,
  input logic              busy,
  input logic              done,
  input logic              errFlag
);

  // R6: a write always follows a read by exactly two cycles
  a_r6_write_after_read: assert property (@(posedge clk) disable iff (!rstN)
    memWrEn |-> $past(memRdEn, 2));

  // R6: any memory strobe or completion happens only while busy
  a_r6_busy_covers: assert property (@(posedge clk) disable iff (!rstN)
    (memRdEn || memWrEn || done) |-> busy);

  // R7: nothing else is accessed in the cycle after the read
  a_r7_gap_after_read: assert property (@(posedge clk) disable iff (!rstN)
    memRdEn |=> (!memRdEn && !memWrEn));

  // R7: the write targets the address that was read
  a_r7_same_addr: assert property (@(posedge clk) disable iff (!rstN)
    memWrEn |-> (memAddr == $past(memAddr, 2)));

  // R7: read, write and completion never overlap
  a_r7_one_action: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({memRdEn, memWrEn, done}));

  // R8: an error completion comes with no write in the previous cycle
  a_r8_err_no_write: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |-> (done && !$past(memWrEn)));

  // R6: a good completion follows the write by one cycle
  a_r6_done_after_write: assert property (@(posedge clk) disable iff (!rstN)
    (done && !errFlag) |-> $past(memWrEn));

endmodule

bind atomic_rmw_unit atomic_rmw_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .memRdEn (memRdEn),
  .memWrEn (memWrEn),
  .memAddr (memAddr),
  .busy    (busy),
  .done    (done),
  .errFlag (errFlag)
);

// File: tb/atomic_rmw_unit_tb.sv
module atomic_rmw_unit_tb;

  localparam int DATA_W = 32;
  localparam int ADDR_W = 8;
  localparam int DISP_W = 16;
  localparam int DEPTH  = 1 << ADDR_W;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              start = 1'b0;
  logic              opSel = 1'b0;
  logic              srcIsReg = 1'b1;
  logic              dstIsMem = 1'b1;
  logic [DISP_W-1:0] disp = '0;
  logic              idx1Used = 1'b0;
  logic [DATA_W-1:0] idx1Val = '0;
  logic              idx2Used = 1'b0;
  logic [DATA_W-1:0] idx2Val = '0;
  logic [DATA_W-1:0] srcVal = '0;
  logic              memRdEn, memWrEn;
  logic [ADDR_W-1:0] memAddr;
  logic [DATA_W-1:0] memWrData;
  logic [DATA_W-1:0] memRdData;
  logic              busy, done, errFlag;
  logic [DATA_W-1:0] oldVal;

  int total = 0;
  int bad   = 0;
  int rdCount = 0;
  int wrCount = 0;
  logic [ADDR_W-1:0] lastWrAddr;

  logic [DATA_W-1:0] mem    [DEPTH];
  logic [DATA_W-1:0] shadow [DEPTH];

  always #5 clk = ~clk;

  atomic_rmw_unit #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .DISP_W(DISP_W)) u_dut (
    .clk(clk), .rstN(rstN), .start(start), .opSel(opSel),
    .srcIsReg(srcIsReg), .dstIsMem(dstIsMem), .disp(disp),
    .idx1Used(idx1Used), .idx1Val(idx1Val), .idx2Used(idx2Used), .idx2Val(idx2Val),
    .srcVal(srcVal), .memRdEn(memRdEn), .memWrEn(memWrEn), .memAddr(memAddr),
    .memWrData(memWrData), .memRdData(memRdData), .busy(busy), .done(done),
    .errFlag(errFlag), .oldVal(oldVal)
  );

  function automatic logic [DATA_W-1:0] seedWord(int i);
    return (32'h9E37_79B9 * (i + 1)) ^ 32'h00A5_5A00;
  endfunction

  // one-cycle synchronous memory owned by the bench
  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= seedWord(i);
      memRdData <= '0;
    end else begin
      if (memWrEn) mem[memAddr] <= memWrData;
      if (memRdEn) memRdData <= mem[memAddr];
    end
  end

  always @(posedge clk) begin
    if (rstN && memRdEn) rdCount <= rdCount + 1;
    if (rstN && memWrEn) begin
      wrCount    <= wrCount + 1;
      lastWrAddr <= memAddr;
    end
  end

  task automatic check(input bit ok, input string req, input logic [DATA_W-1:0] act,
                       input logic [DATA_W-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one request; expectations computed from the requirements
  task automatic runOp(input logic op, input logic sReg, input logic dMem,
                       input int dispV, input logic u1, input logic [31:0] v1,
                       input logic u2, input logic [31:0] v2, input logic [31:0] src,
                       input bit pokeBusy);
    logic [ADDR_W-1:0] expAddr;
    logic [DATA_W-1:0] expOld, expNew;
    int rd0, wr0;
    bit legal;
    legal   = sReg && dMem;
    expAddr = ADDR_W'(dispV + int'(u1 ? v1 : 32'd0) + int'(u2 ? v2 : 32'd0));
    expOld  = shadow[expAddr];
    expNew  = op ? (expOld + src) : src;
    rd0 = rdCount; wr0 = wrCount;
    @(negedge clk);
    start = 1'b1; opSel = op; srcIsReg = sReg; dstIsMem = dMem;
    disp = DISP_W'(dispV); idx1Used = u1; idx1Val = v1; idx2Used = u2; idx2Val = v2;
    srcVal = src;
    @(negedge clk);
    start = 1'b0;
    srcVal = ~src; disp = ~disp; idx1Val = ~v1;
    if (!legal) begin
      check(done && errFlag && !busy == 1'b0 && busy, "R8 err pulse", {done, errFlag}, 2'b11);
      @(negedge clk);
      check(!busy && !done && (rdCount == rd0) && (wrCount == wr0), "R8 no access",
            rdCount - rd0 + wrCount - wr0, 0);
      return;
    end
    check(memRdEn && busy && memAddr == expAddr, "R2 R6 read cycle", memAddr, expAddr);
    @(negedge clk);
    if (pokeBusy) begin
      start = 1'b1; opSel = ~op; srcIsReg = 1'b0;
    end
    check(!memRdEn && !memWrEn && busy, "R7 gap", {memRdEn, memWrEn}, 0);
    @(negedge clk);
    start = 1'b0; srcIsReg = 1'b1;
    check(memWrEn && memWrData == expNew, op ? "R5 write data" : "R4 write data",
          memWrData, expNew);
    @(negedge clk);
    check(done && !errFlag && oldVal == expOld, op ? "R5 old value" : "R4 old value",
          oldVal, expOld);
    @(negedge clk);
    check(!busy && !done, pokeBusy ? "R9 start ignored" : "R6 idle again", busy, 0);
    check(rdCount == rd0 + 1 && wrCount == wr0 + 1 && lastWrAddr == expAddr,
          "R7 one read one write", lastWrAddr, expAddr);
    check(mem[expAddr] == expNew, "R2 memory word", mem[expAddr], expNew);
    shadow[expAddr] = expNew;
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 2000, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) shadow[i] = seedWord(i);
    repeat (3) @(negedge clk);
    check(!busy && !done && !errFlag && !memRdEn && !memWrEn, "R1 reset",
          {busy, done, errFlag, memRdEn, memWrEn}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(!busy && !done && !errFlag && !memRdEn && !memWrEn, "R1 after reset",
          {busy, done, errFlag, memRdEn, memWrEn}, 0);
    // sweep: op x index-slot usage x displacement sign; unused slots carry junk (R3)
    for (int op = 0; op < 2; op++)
      for (int pat = 0; pat < 4; pat++)
        for (int ds = 0; ds < 3; ds++) begin
          int dv;
          dv = (ds == 0) ? 40 + pat : (ds == 1) ? -7 - pat : 0; // R10 negative cases
          runOp(op[0], 1'b1, 1'b1, dv, pat[0], 32'd20 + op, pat[1], 32'd100 + ds,
                32'h1000_0000 + op * 16 + pat * 4 + ds, 1'b0);
        end
    // R10 negative displacement wrapping below zero address
    runOp(1'b1, 1'b1, 1'b1, -3, 1'b1, 32'd1, 1'b0, 32'hDEAD_BEEF, 32'd5, 1'b0);
    // R5 modulo 2^32 wrap on fetch-and-add
    runOp(1'b1, 1'b1, 1'b1, 17, 1'b0, 32'hFFFF, 1'b0, 32'h1234, 32'hFFFF_FFFF, 1'b0);
    runOp(1'b1, 1'b1, 1'b1, 17, 1'b0, 32'h0, 1'b0, 32'h0, 32'hF000_0001, 1'b0);
    // R3 both slots unused with large junk values
    runOp(1'b0, 1'b1, 1'b1, 9, 1'b0, 32'hFFFF_FF00, 1'b0, 32'h7777_7777, 32'hCAFE, 1'b0);
    // R9 start raised mid-operation
    runOp(1'b0, 1'b1, 1'b1, 60, 1'b1, 32'd2, 1'b0, 32'd0, 32'hABCD_0001, 1'b1);
    runOp(1'b1, 1'b1, 1'b1, 60, 1'b1, 32'd2, 1'b0, 32'd0, 32'd3, 1'b1);
    // R8 illegal operand kinds
    runOp(1'b0, 1'b0, 1'b1, 5, 1'b0, 0, 1'b0, 0, 32'h1, 1'b0);
    runOp(1'b1, 1'b1, 1'b0, 5, 1'b0, 0, 1'b0, 0, 32'h1, 1'b0);
    runOp(1'b1, 1'b0, 1'b0, 5, 1'b0, 0, 1'b0, 0, 32'h1, 1'b0);
    check(mem[5] == shadow[5], "R8 word untouched", mem[5], shadow[5]);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule